// File: doc/BRIEF.md
# Area-Decoded Asynchronous Memory Bus Controller

This block turns single internal transfer requests into cycles on an external asynchronous SRAM/ROM bus. Each request carries a 24-bit address, a direction, a size (byte or halfword) and write data. The top address bits pick one of four areas. Each area has its own active-low chip select, a bus-width setting (8 or 16 bits) and a wait count from 0 to 3. A halfword aimed at an 8-bit area is carried out as two byte cycles.

Every access starts with one setup cycle in which the chip select and address are driven and the strobes are still inactive. Zero or more wait cycles follow, then a final strobe cycle. An external active-low wait input can stretch the access beyond its programmed wait count. When a read is directly followed by a write, or by an access to a different area, the block inserts one idle cycle with every chip select released, so that two drivers never meet on the data bus. Read data and a one-cycle done strobe come back together. A new request can be accepted in the final cycle of the current access.

Top module: `xbus_area_ctrl`

## Requirements
- R1: While reset is asserted and right after it, every chip select is high, the read strobe is high, both write lane strobes are high, the data drive enable is low, done is low and request ready is high.
- R2: Address bits [23:22] select the area, and only chip select n (active low, bit n of the chip-select port) is low for the whole access to area n.
- R3: When the wait input stays high, an access to an area with programmed wait count W keeps its chip select low for exactly 2+W cycles.
- R4: The wait input is sampled only at the end of the last programmed wait cycle, or at the end of the setup cycle when W is 0. Each low sample adds one more wait cycle, and low values seen before the sample point have no effect.
- R5: In the setup cycle of each bus cycle the strobes are inactive. From the second cycle up to and including the final cycle the strobe is active. Chip select and address do not change within a bus cycle.
- R6: A halfword access to a 16-bit area is a single bus cycle with address bit 0 forced to 0 and both lane strobes active. Write data goes out unchanged, and read data is returned as the full 16-bit bus word.
- R7: For a byte access to a 16-bit area, an even address uses the upper lane (bits [15:8], write strobe bit 1) and an odd address uses the lower lane (bits [7:0], write strobe bit 0). An 8-bit area always uses the lower lane and write strobe bit 0. The write byte is request data [7:0], and a read returns the byte zero-extended.
- R8: A halfword access to an 8-bit area is two byte cycles. The first goes to the even address and carries data bits [15:8]; the second goes to the odd address and carries bits [7:0]. A single done strobe follows the second cycle.
- R9: If a request is accepted in the final cycle of a read and it is a write or targets another area, exactly one cycle with all chip selects high comes before its setup cycle. Any other back-to-back request starts its setup cycle immediately.
- R10: Done is a one-cycle pulse in the cycle after the final strobe cycle, with the read data valid in that cycle. Request ready is high when the block is idle or in the final cycle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wait | input | 8 | Per-area wait count, 2 bits per area, area 0 in the low bits |
| cfg_wide | input | 4 | Per-area bus width, 1 = 16-bit, 0 = 8-bit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_addr | input | 24 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_half | input | 1 | 1 = halfword, 0 = byte |
| req_wdata | input | 16 | Write data (byte in [7:0]) |
| rsp_done | output | 1 | Access complete pulse |
| rsp_rdata | output | 16 | Read data, valid with done |
| bus_addr | output | 24 | External address |
| bus_cs_n | output | 4 | Active-low chip selects, one per area |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_we_n | output | 2 | Active-low write strobes, bit 1 upper lane, bit 0 lower lane |
| bus_dout | output | 16 | Write data driven to the bus |
| bus_oe | output | 1 | Data bus drive enable during writes |
| bus_din | input | 16 | Read data from the bus |
| bus_wait_n | input | 1 | Active-low external wait request |

## Verification
The completion of one access (its done pulse and read data) and the start of the next (either its setup cycle or the inserted idle cycle) can fall in the same clock cycle. They coincide when a second request is held valid while the first is still in its setup cycle, so that it is taken in the final strobe cycle. The bench then samples the cycle that follows. It expects done to be high and the chip selects to be either all released (read followed by a write or by another area) or already showing the new area's select with strobes idle. After that it confirms that the second access still completes.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int BUS_DW = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_T1,
    ST_TW,
    ST_T2
  } xb_state_e;

  // Active-high lane enables: bit 1 = upper lane, bit 0 = lower lane.
  function automatic logic [1:0] lane_mask(input logic wide, input logic half,
                                           input logic a0);
    if (!wide)     return 2'b01;
    else if (half) return 2'b11;
    else if (a0)   return 2'b01;
    else           return 2'b10;
  endfunction

  // Write data placement on the bus.
  function automatic logic [BUS_DW-1:0] wr_lanes(input logic wide, input logic half,
                                                 input logic part,
                                                 input logic [BUS_DW-1:0] wd);
    logic [BYTE_W-1:0] b;
    if (wide && half) return wd;
    if (!wide && half) b = part ? wd[BYTE_W-1:0] : wd[BUS_DW-1:BYTE_W];
    else               b = wd[BYTE_W-1:0];
    return {b, b};
  endfunction

  // Read data assembly, big-endian for split halfwords.
  function automatic logic [BUS_DW-1:0] rd_merge(input logic wide, input logic half,
                                                 input logic a0,
                                                 input logic [BYTE_W-1:0] hi,
                                                 input logic [BUS_DW-1:0] din);
    if (wide && half) return din;
    if (!wide && half) return {hi, din[BYTE_W-1:0]};
    if (wide && !a0) return {{BYTE_W{1'b0}}, din[BUS_DW-1:BYTE_W]};
    return {{BYTE_W{1'b0}}, din[BYTE_W-1:0]};
  endfunction

endpackage

// File: rtl/xbus_area_dec.sv
module xbus_area_dec #(
  parameter int ADDR_W = 24,
  parameter int N_AREA = 4,
  parameter int WAIT_W = 2,
  parameter int AREA_W = (N_AREA > 1) ? $clog2(N_AREA) : 1
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [N_AREA*WAIT_W-1:0] cfg_wait,
  input  logic [N_AREA-1:0]        cfg_wide,
  output logic [AREA_W-1:0]        area,
  output logic [N_AREA-1:0]        sel,
  output logic [WAIT_W-1:0]        wait_prog,
  output logic                     wide
);

  assign area = addr[ADDR_W-1 -: AREA_W];

  for (genvar g = 0; g < N_AREA; g++) begin : g_sel
    assign sel[g] = (area == AREA_W'(g));
  end

  assign wait_prog = cfg_wait[area*WAIT_W +: WAIT_W];
  assign wide      = cfg_wide[area];

endmodule

// File: rtl/xbus_wait_timer.sv
module xbus_wait_timer #(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_t1,
  input  logic              in_tw,
  input  logic [WAIT_W-1:0] prog,
  input  logic              wait_n,
  output logic              smp,
  output logic              go_t2
);

  localparam logic [WAIT_W-1:0] ONE  = WAIT_W'(1);
  localparam logic [WAIT_W-1:0] ZERO = '0;

  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= ZERO;
    else if (in_t1)              cnt <= prog;
    else if (in_tw && cnt > ONE) cnt <= cnt - ONE;
  end

  // Sample point: end of setup when no waits, else end of last programmed wait.
  assign smp   = (in_t1 && prog == ZERO) || (in_tw && cnt <= ONE);
  assign go_t2 = smp && wait_n;

  AST_WAIT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_tw && !smp |=> in_tw); // R4
  AST_WAIT_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    smp && !wait_n |=> in_tw); // R4

endmodule

// File: rtl/xbus_lane_unit.sv
module xbus_lane_unit
  import xbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              final_part,
  input  logic              wide,
  input  logic              half,
  input  logic              a0,
  input  logic              part,
  input  logic [BUS_DW-1:0] din,
  input  logic [BUS_DW-1:0] wd,
  output logic [BUS_DW-1:0] dout,
  output logic [1:0]        lanes,
  output logic [BUS_DW-1:0] rdata
);

  logic [BYTE_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q  <= '0;
      rdata <= '0;
    end else if (cap) begin
      if (!final_part) hi_q <= din[BYTE_W-1:0];
      else             rdata <= rd_merge(wide, half, a0, hi_q, din);
    end
  end

  assign dout  = wr_lanes(wide, half, part, wd);
  assign lanes = lane_mask(wide, half, a0);

endmodule

// File: rtl/xbus_area_ctrl.sv
module xbus_area_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int N_AREA = 4,
  parameter int WAIT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_AREA*WAIT_W-1:0] cfg_wait,
  input  logic [N_AREA-1:0]        cfg_wide,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic                     req_half,
  input  logic [15:0]              req_wdata,
  output logic                     rsp_done,
  output logic [15:0]              rsp_rdata,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic [N_AREA-1:0]        bus_cs_n,
  output logic                     bus_rd_n,
  output logic [1:0]               bus_we_n,
  output logic [15:0]              bus_dout,
  output logic                     bus_oe,
  input  logic [15:0]              bus_din,
  input  logic                     bus_wait_n
);

  localparam int AREA_W = (N_AREA > 1) ? $clog2(N_AREA) : 1;

  xb_state_e          st;
  logic [ADDR_W-1:0]  r_addr;
  logic               r_wr;
  logic               r_half;
  logic [BUS_DW-1:0]  r_wd;
  logic               part;
  logic               done_q;

  logic [AREA_W-1:0]  cur_area;
  logic [N_AREA-1:0]  cur_sel;
  logic [WAIT_W-1:0]  cur_wait;
  logic               cur_wide;
  logic [AREA_W-1:0]  req_area;

  // Named internal events
  logic in_t1, in_tw, in_t2, acc_active, strobe_on;
  logic split, final_part, accept, rd_end, need_gap;
  logic wait_smp, go_t2;
  logic [1:0] lanes;

  xbus_area_dec #(
    .ADDR_W(ADDR_W), .N_AREA(N_AREA), .WAIT_W(WAIT_W), .AREA_W(AREA_W)
  ) u_dec (
    .addr(r_addr), .cfg_wait(cfg_wait), .cfg_wide(cfg_wide),
    .area(cur_area), .sel(cur_sel), .wait_prog(cur_wait), .wide(cur_wide)
  );

  assign req_area   = req_addr[ADDR_W-1 -: AREA_W];
  assign in_t1      = (st == ST_T1);
  assign in_tw      = (st == ST_TW);
  assign in_t2      = (st == ST_T2);
  assign acc_active = in_t1 || in_tw || in_t2;
  assign strobe_on  = in_tw || in_t2;
  assign split      = r_half && !cur_wide;
  assign final_part = !split || part;
  assign req_ready  = (st == ST_IDLE) || (in_t2 && final_part);
  assign accept     = req_valid && req_ready;
  assign rd_end     = in_t2 && final_part && !r_wr;
  assign need_gap   = rd_end && (req_write || (req_area != cur_area));

  xbus_wait_timer #(.WAIT_W(WAIT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .in_t1(in_t1), .in_tw(in_tw),
    .prog(cur_wait), .wait_n(bus_wait_n), .smp(wait_smp), .go_t2(go_t2)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      r_addr <= '0;
      r_wr   <= 1'b0;
      r_half <= 1'b0;
      r_wd   <= '0;
      part   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= in_t2 && final_part;
      case (st)
        ST_IDLE: if (accept) st <= ST_T1;
        ST_GAP:  st <= ST_T1;
        ST_T1:   st <= go_t2 ? ST_T2 : ST_TW;
        ST_TW:   if (go_t2) st <= ST_T2;
        ST_T2: begin
          if (!final_part) begin
            part <= 1'b1;
            st   <= ST_T1;
          end else if (accept) begin
            st <= need_gap ? ST_GAP : ST_T1;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (accept) begin
        r_addr <= req_addr;
        r_wr   <= req_write;
        r_half <= req_half;
        r_wd   <= req_wdata;
        part   <= 1'b0;
      end
    end
  end

  xbus_lane_unit u_lane (
    .clk(clk), .rst_n(rst_n), .cap(in_t2 && !r_wr), .final_part(final_part),
    .wide(cur_wide), .half(r_half), .a0(r_addr[0]), .part(part),
    .din(bus_din), .wd(r_wd), .dout(bus_dout), .lanes(lanes), .rdata(rsp_rdata)
  );

  assign rsp_done = done_q;
  assign bus_addr = {r_addr[ADDR_W-1:1], r_half ? part : r_addr[0]};
  assign bus_cs_n = acc_active ? ~cur_sel : '1;
  assign bus_rd_n = !(strobe_on && !r_wr);
  assign bus_we_n = ~(lanes & {2{strobe_on && r_wr}});
  assign bus_oe   = acc_active && r_wr;

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~bus_cs_n) <= 1); // R2
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |-> $stable(bus_cs_n) && $stable(bus_addr)); // R5
  AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_t1 |-> bus_rd_n && (bus_we_n == 2'b11)); // R5
  AST_SPLIT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    in_t1 && split && !part |-> !bus_addr[0]); // R8
  AST_READ_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    accept && need_gap |=> (bus_cs_n == '1)); // R9
  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R10

endmodule

// File: tb/xbus_area_ctrl_bench.sv
module xbus_area_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CFG_WAIT = {2'd3, 2'd2, 2'd1, 2'd0};
  localparam logic [3:0] CFG_WIDE = 4'b0101;
  localparam int NVEC = 12;
  // {addr[23:0], write, half, wdata[15:0], wait-low cycles[3:0]}
  localparam logic [45:0] VEC [NVEC] = '{
    {24'h000010, 1'b0, 1'b1, 16'h0000, 4'd0},
    {24'h000020, 1'b1, 1'b1, 16'hBEEF, 4'd0},
    {24'h800033, 1'b0, 1'b0, 16'h0000, 4'd0},
    {24'h800034, 1'b0, 1'b0, 16'h0000, 4'd2},
    {24'h800035, 1'b1, 1'b0, 16'h00A7, 4'd4},
    {24'h000036, 1'b1, 1'b0, 16'h005C, 4'd0},
    {24'h400041, 1'b0, 1'b1, 16'h0000, 4'd0},
    {24'h400050, 1'b1, 1'b1, 16'h1234, 4'd3},
    {24'hC00007, 1'b0, 1'b0, 16'h0000, 4'd0},
    {24'hC00100, 1'b1, 1'b1, 16'hCAFE, 4'd0},
    {24'hC00202, 1'b0, 1'b1, 16'h0000, 4'd5},
    {24'h800100, 1'b0, 1'b1, 16'h0000, 4'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_half = 1'b0, bus_wait_n = 1'b1;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_done, bus_rd_n, bus_oe;
  logic [15:0] rsp_rdata, bus_dout, bus_din;
  logic [23:0] bus_addr;
  logic [3:0] bus_cs_n;
  logic [1:0] bus_we_n;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_area_ctrl u_xbus_area_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wait(CFG_WAIT), .cfg_wide(CFG_WIDE),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_half(req_half), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din), .bus_wait_n(bus_wait_n)
  );

  function automatic logic [7:0] bval(input logic [23:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h6B;
  endfunction

  // Memory model: 16-bit areas return big-endian pairs, 8-bit areas a byte.
  always_comb begin
    if (CFG_WIDE[bus_addr[23:22]])
      bus_din = {bval({bus_addr[23:1], 1'b0}), bval({bus_addr[23:1], 1'b1})};
    else
      bus_din = {8'hEE, bval(bus_addr)};
  end

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic run_access(input logic [23:0] a, input logic wr, input logic hf,
                            input logic [15:0] wd, input int k);
    int area, w, part1, exp_cs, nt1_exp, ncs, nstb, nt1, csbad;
    bit wide, split, seen;
    logic [23:0] cap_a [2];
    logic [1:0]  cap_we [2];
    logic [15:0] cap_d [2];
    logic [15:0] rd, exp_rd;
    logic [7:0]  lane0;
    string tag;
    area = int'(a[23:22]); w = area; wide = CFG_WIDE[area]; split = hf && !wide;
    part1 = 2 + w + ((k > w) ? (k - w) : 0);
    exp_cs = part1 + (split ? 2 + w : 0);
    nt1_exp = split ? 2 : 1;
    ncs = 0; nstb = 0; nt1 = 0; csbad = 0; seen = 0; rd = '0;
    cap_a = '{default: '0}; cap_we = '{default: '1}; cap_d = '{default: '0};
    @(negedge clk);
    chk("R10 ready idle", 48'(req_ready), 48'd1);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_half = hf; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 1; c <= 60; c++) begin
      bus_wait_n = !(c <= k);
      if (rsp_done) begin seen = 1; rd = rsp_rdata; break; end
      if (bus_cs_n != 4'hF) begin
        ncs++;
        if (bus_cs_n != ~(4'b0001 << area)) csbad++;
        if (bus_rd_n && bus_we_n == 2'b11) nt1++;
        else begin
          nstb++;
          if (nt1 >= 1 && nt1 <= 2) begin
            cap_a[nt1-1] = bus_addr; cap_we[nt1-1] = bus_we_n; cap_d[nt1-1] = bus_dout;
          end
        end
      end
      @(negedge clk);
    end
    bus_wait_n = 1'b1;
    chk("R10 done seen", 48'(seen), 48'd1);
    chk("R2 select", 48'(csbad), 48'd0);
    chk((k > w) ? "R4 length" : "R3 length", 48'(ncs), 48'(exp_cs));
    chk("R5 phases", {16'(nt1), 32'(nstb)}, {16'(nt1_exp), 32'(exp_cs - nt1_exp)});
    tag = (wide && hf) ? "R6" : (split ? "R8" : "R7");
    if (!wr) begin
      exp_rd = hf ? {bval({a[23:1], 1'b0}), bval({a[23:1], 1'b1})} : {8'h00, bval(a)};
      chk({tag, " read data"}, 48'(rd), 48'(exp_rd));
    end else if (wide && hf) begin
      chk("R6 write", {cap_a[0], cap_we[0], 6'd0, cap_d[0]}, {a[23:1], 1'b0, 2'b00, 6'd0, wd});
    end else if (split) begin
      chk("R8 write even", {cap_a[0], cap_we[0], 14'd0, cap_d[0][7:0]},
          {a[23:1], 1'b0, 2'b10, 14'd0, wd[15:8]});
      chk("R8 write odd", {cap_a[1], cap_we[1], 14'd0, cap_d[1][7:0]},
          {a[23:1], 1'b1, 2'b10, 14'd0, wd[7:0]});
    end else begin
      lane0 = (wide && !a[0]) ? cap_d[0][15:8] : cap_d[0][7:0];
      chk("R7 write", {cap_a[0], cap_we[0], 14'd0, lane0},
          {a, (wide && !a[0]) ? 2'b01 : 2'b10, 14'd0, wd[7:0]});
    end
  endtask

  // Second request taken in the final cycle of the first (first is area 0, W=0).
  task automatic back_to_back(input logic w1, input logic [23:0] a2, input logic w2,
                              input logic gap, input logic [3:0] exp_cs);
    bit seen;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 24'h000100; req_write = w1; req_half = 1'b1;
    req_wdata = 16'h5A5A;
    @(negedge clk);
    req_addr = a2; req_write = w2; req_half = 1'b0; req_wdata = 16'h0033;
    @(negedge clk);
    chk("R10 ready final", 48'({req_ready, bus_cs_n}), 48'({1'b1, 4'b1110}));
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 done overlap", 48'(rsp_done), 48'd1);
    chk(gap ? "R9 gap" : "R9 no gap", 48'({bus_cs_n, bus_rd_n, bus_we_n}),
        48'({gap ? 4'hF : exp_cs, 1'b1, 2'b11}));
    seen = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (rsp_done) begin seen = 1; break; end
    end
    chk("R10 second done", 48'(seen), 48'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [45:0] v;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 48'({bus_cs_n, bus_rd_n, bus_we_n, bus_oe, rsp_done, req_ready}),
        48'({4'hF, 1'b1, 2'b11, 1'b0, 1'b0, 1'b1}));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 48'({bus_cs_n, bus_rd_n, bus_we_n, bus_oe, rsp_done, req_ready}),
        48'({4'hF, 1'b1, 2'b11, 1'b0, 1'b0, 1'b1}));

    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      run_access(v[45:22], v[21], v[20], v[19:4], int'(v[3:0]));
    end

    back_to_back(1'b0, 24'h000200, 1'b1, 1'b1, 4'hF);
    back_to_back(1'b0, 24'h800200, 1'b0, 1'b1, 4'hF);
    back_to_back(1'b0, 24'h000201, 1'b0, 1'b0, 4'b1110);
    back_to_back(1'b1, 24'h800201, 1'b0, 1'b0, 4'b1011);

    // Reset in the middle of a long write access
    @(negedge clk);
    req_valid = 1'b1; req_addr = 24'hC00010; req_write = 1'b1; req_half = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-access reset", 48'({bus_cs_n, bus_rd_n, bus_we_n, bus_oe, rsp_done, req_ready}),
        48'({4'hF, 1'b1, 2'b11, 1'b0, 1'b0, 1'b1}));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    summary();
  end

endmodule